// File: doc/BRIEF.md
# Transmit Buffer and Interrupt Status Controller

This block holds the characters a CPU writes for a serial transmitter and decides when the transmitter asks for more. Characters enter a transmit buffer through a one-cycle write strobe. The buffer has one entry or a four-entry FIFO, chosen by a parameter. A shift register drains the buffer one bit per `bit_tick_i` pulse, least significant bit first. When a synchronous frame with CRC runs out of data, the shifter appends the two CRC bytes given on `crc_bytes_i` and then the flag or sync character on `flag_char_i`, without any help from the CPU.

Two status views come out of the block:
- `buf_empty_o` means the entry location can take another character.
- `tx_ip_o` is the transmit interrupt pending flag. It sets only on specific events:
  - the buffer empties, with the exact event picked by a FIFO mode bit;
  - the handoff from the second CRC byte to the flag character.

The request `irq_o` is the pending flag gated by both the transmit interrupt enable and the master interrupt enable. Two sticky bits catch misuse. One is a write into a full buffer. The other is a write that lands while CRC bytes are on the line, which means the frame end was corrupted.

Top module: `tx_buffer_irq_ctrl`

## Requirements
- R1: `irq_o` is high only while `tx_ip_o`, `tx_ie_i` and `master_ie_i` are all high.
- R2: After `rst_n` low or a `chan_reset_i` cycle, the block is in its idle state:
  - `buf_empty_o`=1, `tx_ip_o`=0, `overflow_o`=0 and `bad_end_o`=0;
  - `txd_o`=1 (idle line);
  - the buffer holds no characters.
- R3: Enabling transmit interrupts while the buffer is empty does not set `tx_ip_o`. With DEPTH=1, `tx_ip_o` sets in the cycle after the shifter takes the only stored character, which takes the buffer from full to empty.
- R4: With DEPTH=4 and `drain_mode_i`=0, `tx_ip_o` sets when the shifter takes a character from a full FIFO, which frees the entry location. Taking the last of fewer stored characters does not set it.
- R5: With DEPTH=4 and `drain_mode_i`=1, `tx_ip_o` sets only when a load leaves the FIFO with zero characters.
- R6: `buf_empty_o` is 1 exactly when fewer than DEPTH characters are stored. It does not depend on `drain_mode_i` or on `tx_ip_o`.
- R7: `tx_ip_o` clears in the cycle after an accepted write or a `reset_txip_i` pulse. If a set event falls in the same cycle, the set wins.
- R8: Shifter timing works as follows:
  - On a tick while idle, the shifter loads the next character and presents bit 0 on `txd_o`.
  - Each following tick presents the next bit.
  - After 8 ticks the shifter loads again.
- R9: This requirement covers the case where `sync_mode_i`=1, `crc_en_i`=1 and the buffer is empty when a data character finishes.
  - The shifter then sends `crc_bytes_i[7:0]`, then `crc_bytes_i[15:8]`, then `flag_char_i`, each LSB first.
  - `tx_ip_o` sets as the flag character is loaded.
- R10: A write accepted while either CRC byte is in the shifter sets sticky `bad_end_o`. Only a reset clears it.
- R11: A write while `buf_empty_o`=0 is dropped and sets sticky `overflow_o`. Only a reset clears it.
- R12: No set event raises `tx_ip_o` while `tx_ie_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| chan_reset_i | input | 1 | Synchronous channel reset |
| wr_en_i | input | 1 | CPU write strobe into the transmit buffer |
| wr_data_i | input | 8 | Character to write |
| bit_tick_i | input | 1 | Advance the shift register by one bit |
| sync_mode_i | input | 1 | 1 = synchronous framing |
| crc_en_i | input | 1 | 1 = append CRC and flag when data runs out |
| crc_bytes_i | input | 16 | CRC value; low byte goes out first |
| flag_char_i | input | 8 | Flag or sync character that closes a frame |
| master_ie_i | input | 1 | Master interrupt enable |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| drain_mode_i | input | 1 | FIFO interrupt mode: 0 = entry freed, 1 = fully drained |
| reset_txip_i | input | 1 | Command pulse clearing the pending flag |
| txd_o | output | 1 | Serial data out |
| buf_empty_o | output | 1 | Entry location can accept a character |
| tx_ip_o | output | 1 | Transmit interrupt pending |
| irq_o | output | 1 | Gated transmit interrupt request |
| overflow_o | output | 1 | Sticky: write into a full buffer |
| bad_end_o | output | 1 | Sticky: write landed during CRC transmission |

## Verification
A one-entry and a four-entry instance share one stimulus, so every buffer pattern shows both depths side by side.

Several patterns exercise the pending-flag logic:
- A single character drained one way sets the flag at depth one but not in the four-entry entry mode. This separates the full-to-empty rule from the entry-freed rule.
- A fully loaded FIFO drained in the other mode shows the flag rising on the fourth load and not earlier. This separates draining from entry freeing, and it also confirms that the overflowing fifth write was dropped.
- A synchronous frame is followed bit by bit through data, both CRC bytes and the flag, which places the handoff interrupt on the exact tick.

A write injected during the first CRC byte checks the illegal-termination flag.

// File: rtl/txb_pkg.sv
package txb_pkg;

    // What the transmit shift register currently holds
    typedef enum logic [2:0] {
        SK_IDLE   = 3'd0,
        SK_DATA   = 3'd1,
        SK_CRC_LO = 3'd2,
        SK_CRC_HI = 3'd3,
        SK_FLAG   = 3'd4
    } shift_kind_e;

endpackage

// File: rtl/txb_fifo.sv
module txb_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             has_space,
    output logic             nonempty
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PTR_W-1:0]         rd;
        logic [PTR_W-1:0]         wr;
        logic [CNT_W-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t q, d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d = q;
        if (clr) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end else begin
            if (push) begin
                d.mem[q.wr] = push_data;
                d.wr        = ptr_inc(q.wr);
            end
            if (pop) begin
                d.rd = ptr_inc(q.rd);
            end
            case ({push, pop})
                2'b10:   d.cnt = q.cnt + CNT_W'(1);
                2'b01:   d.cnt = q.cnt - CNT_W'(1);
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head      = q.mem[q.rd];
    assign count     = q.cnt;
    assign has_space = (q.cnt < CNT_W'(DEPTH));
    assign nonempty  = (q.cnt != '0);

endmodule

// File: rtl/txb_shifter.sv
module txb_shifter
    import txb_pkg::*;
#(
    parameter int DW = 8,
    localparam int BIT_W = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bit_tick,
    input  logic          sync_mode,
    input  logic          crc_en,
    input  logic          fifo_nonempty,
    input  logic [DW-1:0] head,
    input  logic [2*DW-1:0] crc_bytes,
    input  logic [DW-1:0] flag_char,
    output logic          pop,
    output logic          flag_handoff,
    output logic          txd,
    output shift_kind_e   kind
);

    typedef struct packed {
        logic [DW-1:0]    sh;
        logic [BIT_W-1:0] cnt;
        shift_kind_e      kind;
    } shift_st_t;

    shift_st_t   q, d;
    logic        load;
    shift_kind_e nxt;
    logic [DW-1:0] nsh;

    // Choose what enters the shifter at the next load point
    always_comb begin
        if (q.kind == SK_CRC_LO)                         nxt = SK_CRC_HI;
        else if (q.kind == SK_CRC_HI)                    nxt = SK_FLAG;
        else if (fifo_nonempty)                          nxt = SK_DATA;
        else if (q.kind == SK_DATA && sync_mode && crc_en) nxt = SK_CRC_LO;
        else                                             nxt = SK_IDLE;

        case (nxt)
            SK_DATA:   nsh = head;
            SK_CRC_LO: nsh = crc_bytes[DW-1:0];
            SK_CRC_HI: nsh = crc_bytes[2*DW-1:DW];
            SK_FLAG:   nsh = flag_char;
            default:   nsh = '1;
        endcase
    end

    assign load = bit_tick && (q.kind == SK_IDLE || q.cnt == BIT_W'(DW - 1));

    always_comb begin
        d            = q;
        pop          = 1'b0;
        flag_handoff = 1'b0;
        if (clr) begin
            d.sh   = '1;
            d.cnt  = '0;
            d.kind = SK_IDLE;
        end else if (load) begin
            d.sh         = nsh;
            d.cnt        = '0;
            d.kind       = nxt;
            pop          = (nxt == SK_DATA);
            flag_handoff = (q.kind == SK_CRC_HI);
        end else if (bit_tick) begin
            d.sh  = {1'b1, q.sh[DW-1:1]};
            d.cnt = q.cnt + BIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sh: '1, cnt: '0, kind: SK_IDLE};
        else        q <= d;
    end

    assign txd  = (q.kind == SK_IDLE) ? 1'b1 : q.sh[0];
    assign kind = q.kind;

endmodule

// File: rtl/txb_irq.sv
module txb_irq #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pop,
    input  logic             wr_accept,
    input  logic             wr_reject,
    input  logic [CNT_W-1:0] count,
    input  logic             tx_ie,
    input  logic             drain_mode,
    input  logic             flag_handoff,
    input  logic             crc_busy,
    input  logic             reset_cmd,
    output logic             ip,
    output logic             overflow,
    output logic             bad_end
);

    typedef struct packed {
        logic ip;
        logic ovf;
        logic bad;
    } irq_st_t;

    irq_st_t q, d;
    logic    fifo_evt;
    logic    set_evt;

    generate
        if (DEPTH == 1) begin : g_single
            // Only one event exists: the single entry moves to the shifter
            assign fifo_evt = pop && (count == CNT_W'(1));
        end else begin : g_fifo
            logic entry_evt;
            logic drain_evt;
            assign entry_evt = pop && (count == CNT_W'(DEPTH));
            assign drain_evt = pop && (count == CNT_W'(1)) && !wr_accept;
            assign fifo_evt  = drain_mode ? drain_evt : entry_evt;
        end
    endgenerate

    assign set_evt = tx_ie && (fifo_evt || flag_handoff);

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (set_evt)                     d.ip = 1'b1;
            else if (wr_accept || reset_cmd) d.ip = 1'b0;
            if (wr_reject)                   d.ovf = 1'b1;
            if (wr_accept && crc_busy)       d.bad = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ip       = q.ip;
    assign overflow = q.ovf;
    assign bad_end  = q.bad;

endmodule

// File: rtl/tx_buffer_irq_ctrl.sv
module tx_buffer_irq_ctrl
    import txb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chan_reset_i,
    input  logic            wr_en_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic            bit_tick_i,
    input  logic            sync_mode_i,
    input  logic            crc_en_i,
    input  logic [2*DW-1:0] crc_bytes_i,
    input  logic [DW-1:0]   flag_char_i,
    input  logic            master_ie_i,
    input  logic            tx_ie_i,
    input  logic            drain_mode_i,
    input  logic            reset_txip_i,
    output logic            txd_o,
    output logic            buf_empty_o,
    output logic            tx_ip_o,
    output logic            irq_o,
    output logic            overflow_o,
    output logic            bad_end_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             has_space;
    logic             nonempty;
    logic [DW-1:0]    head;
    logic [CNT_W-1:0] count;
    logic             pop;
    logic             flag_handoff;
    logic             wr_accept;
    logic             wr_reject;
    logic             crc_busy;
    shift_kind_e      kind;

    assign wr_accept = wr_en_i && has_space  && !chan_reset_i;
    assign wr_reject = wr_en_i && !has_space && !chan_reset_i;
    assign crc_busy  = (kind == SK_CRC_LO) || (kind == SK_CRC_HI);

    txb_fifo #(.DEPTH(DEPTH), .DW(DW)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (chan_reset_i),
        .push      (wr_accept),
        .push_data (wr_data_i),
        .pop       (pop),
        .head      (head),
        .count     (count),
        .has_space (has_space),
        .nonempty  (nonempty)
    );

    txb_shifter #(.DW(DW)) shift_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (chan_reset_i),
        .bit_tick      (bit_tick_i),
        .sync_mode     (sync_mode_i),
        .crc_en        (crc_en_i),
        .fifo_nonempty (nonempty),
        .head          (head),
        .crc_bytes     (crc_bytes_i),
        .flag_char     (flag_char_i),
        .pop           (pop),
        .flag_handoff  (flag_handoff),
        .txd           (txd_o),
        .kind          (kind)
    );

    txb_irq #(.DEPTH(DEPTH)) irq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (chan_reset_i),
        .pop          (pop),
        .wr_accept    (wr_accept),
        .wr_reject    (wr_reject),
        .count        (count),
        .tx_ie        (tx_ie_i),
        .drain_mode   (drain_mode_i),
        .flag_handoff (flag_handoff),
        .crc_busy     (crc_busy),
        .reset_cmd    (reset_txip_i),
        .ip           (tx_ip_o),
        .overflow     (overflow_o),
        .bad_end      (bad_end_o)
    );

    assign buf_empty_o = has_space;
    assign irq_o       = tx_ip_o && tx_ie_i && master_ie_i;

endmodule

// File: rtl/tx_buffer_irq_ctrl_chk.sv
module tx_buffer_irq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic chan_reset_i,
    input logic wr_en_i,
    input logic master_ie_i,
    input logic tx_ie_i,
    input logic reset_txip_i,
    input logic txd_o,
    input logic buf_empty_o,
    input logic tx_ip_o,
    input logic irq_o,
    input logic overflow_o,
    input logic bad_end_o
);

    // R1
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (master_ie_i && tx_ie_i && tx_ip_o));

    // R2
    chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_reset_i |=> (buf_empty_o && !tx_ip_o && !overflow_o && !bad_end_o && txd_o));

    // R7
    txip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_txip_i && !tx_ie_i && !chan_reset_i) |=> !tx_ip_o);

    // R10
    bad_end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_end_o && !chan_reset_i) |=> bad_end_o);

    // R11
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> ($past(wr_en_i) && !$past(buf_empty_o)));

    // R11
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !chan_reset_i) |=> overflow_o);

    // R12
    ie_gate_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ie_i |=> !$rose(tx_ip_o));

endmodule

bind tx_buffer_irq_ctrl tx_buffer_irq_ctrl_chk chk_i (.*);

// File: tb/tx_buffer_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_buffer_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_reset = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        tick = 1'b0;
    logic        sync_mode = 1'b0;
    logic        crc_en = 1'b0;
    logic [15:0] crc_bytes = 16'hBEEF;
    logic [7:0]  flag_char = 8'h7E;
    logic        mie = 1'b0;
    logic        tie = 1'b0;
    logic        drain = 1'b0;
    logic        rst_ip = 1'b0;

    logic o4_txd, o4_empty, o4_ip, o4_irq, o4_ovf, o4_bad;
    logic o1_txd, o1_empty, o1_ip, o1_irq, o1_ovf, o1_bad;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tx_buffer_irq_ctrl #(.DEPTH(4), .DW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .chan_reset_i(chan_reset),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .bit_tick_i(tick),
        .sync_mode_i(sync_mode), .crc_en_i(crc_en), .crc_bytes_i(crc_bytes),
        .flag_char_i(flag_char), .master_ie_i(mie), .tx_ie_i(tie),
        .drain_mode_i(drain), .reset_txip_i(rst_ip),
        .txd_o(o4_txd), .buf_empty_o(o4_empty), .tx_ip_o(o4_ip),
        .irq_o(o4_irq), .overflow_o(o4_ovf), .bad_end_o(o4_bad)
    );

    tx_buffer_irq_ctrl #(.DEPTH(1), .DW(8)) dut1_i (
        .clk(clk), .rst_n(rst_n), .chan_reset_i(chan_reset),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .bit_tick_i(tick),
        .sync_mode_i(sync_mode), .crc_en_i(crc_en), .crc_bytes_i(crc_bytes),
        .flag_char_i(flag_char), .master_ie_i(mie), .tx_ie_i(tie),
        .drain_mode_i(drain), .reset_txip_i(rst_ip),
        .txd_o(o1_txd), .buf_empty_o(o1_empty), .tx_ip_o(o1_ip),
        .irq_o(o1_irq), .overflow_o(o1_ovf), .bad_end_o(o1_bad)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chan_rst();
        @(negedge clk); chan_reset = 1'b1;
        @(negedge clk); chan_reset = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tick_n(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R2 d4 buf_empty after reset", o4_empty, 1);
        check("R2 d1 buf_empty after reset", o1_empty, 1);
        check("R2 d4 tx_ip after reset", o4_ip, 0);
        check("R2 d4 overflow/bad_end after reset", {o4_ovf, o4_bad}, 0);
        check("R2 txd idle after reset", {o4_txd, o1_txd}, 2'b11);
    endtask

    task automatic t_single_char();
        logic [7:0] bits;
        chan_rst();
        mie = 1'b1; tie = 1'b0; drain = 1'b0; sync_mode = 1'b0; crc_en = 1'b0;
        write_byte(8'hA5);
        check("R6 d1 entry occupied after one write", o1_empty, 0);
        check("R6 d4 entry free with one char", o4_empty, 1);
        @(negedge clk); tick = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            bits[k] = o4_txd;
            if (k == 0) check("R12 d1 no pending while tx_ie low", o1_ip, 0);
        end
        tick = 1'b0;
        check("R8 serial bits LSB first", bits, 8'hA5);
        tie = 1'b1;
        repeat (4) @(negedge clk);
        check("R3 d1 enabling on empty buffer leaves pending clear", o1_ip, 0);
        write_byte(8'h5A);
        tick_n(1);
        check("R3 d1 pending after full-to-empty", o1_ip, 1);
        check("R4 d4 entry mode ignores non-full drain", o4_ip, 0);
        check("R8 next char bit0 on load tick", o1_txd, 0);
        check("R1 d1 irq with both enables", o1_irq, 1);
        @(negedge clk); mie = 1'b0;
        @(negedge clk);
        check("R1 d1 irq masked by master enable", {o1_irq, o1_ip}, 2'b01);
        mie = 1'b1; tie = 1'b0;
        @(negedge clk);
        check("R1 d1 irq masked by tx enable", {o1_irq, o1_ip}, 2'b01);
        tie = 1'b1;
        write_byte(8'h11);
        check("R7 d1 pending cleared by write", o1_ip, 0);
    endtask

    task automatic t_fifo_modes();
        chan_rst();
        check("R2 d1 buf_empty after channel reset", o1_empty, 1);
        drain = 1'b0; tie = 1'b1;
        write_byte(8'h01); write_byte(8'h02); write_byte(8'h03); write_byte(8'h04);
        check("R6 d4 entry not free when full", o4_empty, 0);
        check("R11 d4 no overflow at exactly full", o4_ovf, 0);
        check("R11 d1 overflow after writes past one entry", o1_ovf, 1);
        write_byte(8'h05);
        check("R11 d4 overflow on write to full", o4_ovf, 1);
        tick_n(1);
        check("R4 d4 entry-freed pending", o4_ip, 1);
        check("R6 d4 entry free after one load", o4_empty, 1);
        @(negedge clk); rst_ip = 1'b1; drain = 1'b1;
        @(negedge clk); rst_ip = 1'b0;
        check("R7 d4 pending cleared by command", o4_ip, 0);
        tick_n(23);
        check("R5 d4 no pending before last load", o4_ip, 0);
        check("R6 d4 entry free in drain mode", o4_empty, 1);
        tick_n(1);
        check("R5 d4 pending when FIFO drained (5th write dropped)", o4_ip, 1);
        chan_rst();
        check("R2 d4 overflow cleared by channel reset", o4_ovf, 0);
        check("R2 d4 pending cleared by channel reset", o4_ip, 0);
        check("R2 d4 idle line after channel reset", o4_txd, 1);
    endtask

    task automatic t_crc_frame();
        logic [31:0] bits;
        chan_rst();
        drain = 1'b0; tie = 1'b1; sync_mode = 1'b1; crc_en = 1'b1;
        write_byte(8'h3C);
        @(negedge clk); tick = 1'b1;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            bits[k] = o4_txd;
            if (k == 23) check("R9 no pending before flag load", o4_ip, 0);
            if (k == 24) check("R9 pending at flag handoff", o4_ip, 1);
        end
        tick = 1'b0;
        check("R8 frame data byte", bits[7:0], 8'h3C);
        check("R9 CRC bytes low first", bits[23:8], 16'hBEEF);
        check("R9 flag character closes frame", bits[31:24], 8'h7E);
        check("R6 entry free after frame", o4_empty, 1);
        check("R10 clean frame has no bad end", o4_bad, 0);
    endtask

    task automatic t_bad_end();
        chan_rst();
        write_byte(8'h55);
        @(negedge clk); tick = 1'b1;
        for (int k = 0; k < 11; k++) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h99;
        @(negedge clk); wr_en = 1'b0;
        tick = 1'b0;
        check("R10 d4 write during CRC flags bad end", o4_bad, 1);
        check("R10 d1 write during CRC flags bad end", o1_bad, 1);
        repeat (3) @(negedge clk);
        check("R10 bad end is sticky", o4_bad, 1);
        chan_rst();
        check("R10 bad end cleared by channel reset", {o4_bad, o1_bad}, 0);
        sync_mode = 1'b0; crc_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_single_char();
        t_fifo_modes();
        t_crc_frame();
        t_bad_end();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #400000;
                checks++;
                errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule